// File: doc/BRIEF.md
# Switched-Capacitor Conversion Sequencer

This block sets the timing of one oversampling converter from a single master clock, nominally 112.64 kHz. During a conversion it drives four switching phases in a fixed order, one clock each: sample input, transfer charge, sample reference, transfer charge. A full turn of the four phases is one modulator sample, so the input is sampled at one quarter of the clock (28.16 kHz). After `SAMPLES` samples (512 by default) it waits `POST_DLY` clocks (112 by default) for the filter to finish processing, then pulses data ready.

While idle the block is in shutdown and every output is low. A falling edge on the chip-select input starts one conversion. Holding the continuous-mode input high also starts conversions and chains them back to back. Each start from shutdown first spends `STARTUP_CYC` clocks in a wake-up interval (34 by default, about 300 µs). At the first cycle of every conversion the block clears the decimation filter. At the last phase of every sample it strobes the filter. The serial output block picks up the result when data ready pulses.

Top module: `conv_seq`

## Requirements
- R1: After reset, `busy`, `ph_en`, `filt_clr`, `filt_stb` and `data_rdy` are all low.
- R2: In shutdown, all outputs stay low. Only a falling edge of `cs_n`, or `cont_mode` high, leaves shutdown. A rising edge of `cs_n` does nothing.
- R3: During a conversion, `ph_en` is one-hot and advances one bit per clock. The order is bit 0 (sample input), bit 1 (transfer), bit 2 (sample reference), bit 3 (transfer), then back to bit 0. There are exactly `SAMPLES` bit-0 cycles per conversion.
- R4: A start is sampled on a clock edge E. From that edge, `busy` is high with `ph_en` low for `STARTUP_CYC` cycles. The first phase appears in the cycle after edge E+`STARTUP_CYC`.
- R5: `filt_stb` is high exactly in the bit-3 phase cycles. There are `SAMPLES` strobes per conversion.
- R6: `filt_clr` is a one-cycle pulse in the first cycle of each conversion. It coincides with phase bit 0, and there is one per conversion.
- R7: `data_rdy` is a one-cycle pulse. It comes `POST_DLY`+1 cycles after the last strobe of a conversion. For a start sampled at edge E, it is high in the cycle after edge E+`STARTUP_CYC`+4·`SAMPLES`+`POST_DLY`.
- R8: In one-shot operation (`cont_mode` low), `busy` is already low in the `data_rdy` cycle, and the block stays in shutdown.
- R9: With `cont_mode` high, the next conversion starts (with its `filt_clr`) in the `data_rdy` cycle, without a wake-up interval. Data ready then repeats every 4·`SAMPLES`+`POST_DLY` cycles. `cont_mode` is read at the end of the post delay: if it is low there, the block shuts down after that conversion.
- R10: A `cs_n` falling edge while `busy` is high is ignored: it neither restarts nor extends the current conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select; a falling edge starts a one-shot conversion |
| cont_mode | input | 1 | High selects back-to-back conversions |
| ph_en | output | 4 | One-hot switching phase enables |
| filt_clr | output | 1 | Clears the decimation filter at conversion start |
| filt_stb | output | 1 | Filter sample strobe, once per modulator sample |
| busy | output | 1 | High from start detection until shutdown |
| data_rdy | output | 1 | One-cycle pulse when a result is complete |

## Verification
The bench targets the cycle-exact placement of the first filter clear and of data ready, for both a one-shot start and a continuous chain. An off-by-one in the wake-up or post-delay counter moves one of these by a cycle, and the bench reports it. A second chip-select edge in mid-conversion checks start gating: a design that re-armed would give a late or doubled data-ready pulse. Clearing continuous mode during a conversion checks that exactly one more result arrives before shutdown, and that a chained conversion skips the wake-up interval. A one-hot and ordering monitor on the phases catches a skipped or repeated phase, or a strobe outside the last phase.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int NPH = 4;
  localparam int PW  = $clog2(NPH);

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_RUN  = 2'd2,
    ST_POST = 2'd3
  } seq_state_t;
endpackage

// File: rtl/conv_seq_edge.sv
module conv_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic fall
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign fall = cs_q & ~cs_n;
endmodule

// File: rtl/conv_seq_phase.sv
module conv_seq_phase
  import conv_seq_pkg::*;
#(
  parameter int SAMPLES = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  output logic [NPH-1:0] ph_en,
  output logic           smp_stb,
  output logic           conv_first,
  output logic           conv_last
);
  localparam int SW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [SW-1:0] SMP_LAST = SW'(SAMPLES - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(NPH - 1);

  logic [PW-1:0] phase;
  logic [SW-1:0] smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      smp   <= '0;
    end else if (!run) begin
      phase <= '0;
      smp   <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == PH_LAST) begin
        smp <= (smp == SMP_LAST) ? '0 : smp + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_dec
    assign ph_en[g] = run && (phase == PW'(g));
  end

  assign smp_stb    = run && (phase == PH_LAST);
  assign conv_first = run && (phase == '0) && (smp == '0);
  assign conv_last  = smp_stb && (smp == SMP_LAST);
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int STARTUP_CYC = 34,
  parameter int POST_DLY    = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_fall,
  input  logic cont_mode,
  input  logic conv_last,
  output logic run,
  output logic busy,
  output logic data_rdy
);
  localparam int CMAX = (STARTUP_CYC > POST_DLY) ? STARTUP_CYC : POST_DLY;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WAKE_LOAD = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] POST_LOAD = CW'(POST_DLY - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      unique case (state)
        ST_OFF: begin
          if (start_fall || cont_mode) begin
            state <= ST_WAKE;
            cnt   <= WAKE_LOAD;
          end
        end
        ST_WAKE: begin
          if (cnt == '0) state <= ST_RUN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_RUN: begin
          if (conv_last) begin
            state <= ST_POST;
            cnt   <= POST_LOAD;
          end
        end
        ST_POST: begin
          if (cnt == '0) begin
            rdy_q <= 1'b1;
            state <= cont_mode ? ST_RUN : ST_OFF;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign run      = (state == ST_RUN);
  assign busy     = (state != ST_OFF);
  assign data_rdy = rdy_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int SAMPLES     = 512,
  parameter int POST_DLY    = 112,
  parameter int STARTUP_CYC = 34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cont_mode,
  output logic [3:0] ph_en,
  output logic       filt_clr,
  output logic       filt_stb,
  output logic       busy,
  output logic       data_rdy
);
  logic start_fall;
  logic run;
  logic conv_last;

  conv_seq_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .fall  (start_fall)
  );

  conv_seq_phase #(.SAMPLES(SAMPLES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .ph_en      (ph_en),
    .smp_stb    (filt_stb),
    .conv_first (filt_clr),
    .conv_last  (conv_last)
  );

  conv_seq_ctrl #(
    .STARTUP_CYC (STARTUP_CYC),
    .POST_DLY    (POST_DLY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_fall (start_fall),
    .cont_mode  (cont_mode),
    .conv_last  (conv_last),
    .run        (run),
    .busy       (busy),
    .data_rdy   (data_rdy)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ph_en,
  input logic       filt_clr,
  input logic       filt_stb,
  input logic       busy,
  input logic       data_rdy
);
  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_en));

  // R3
  phase_step01_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en[0] |=> ph_en[1]);

  // R3
  phase_step12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en[1] |=> ph_en[2]);

  // R3
  phase_step23_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en[2] |=> ph_en[3]);

  // R5
  stb_last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_stb |-> ph_en[3]);

  // R6
  clr_first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clr |-> ph_en[0]);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ph_en == 4'b0000 && !filt_stb && !filt_clr));

  // R4
  wake_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ph_en == 4'b0000));

  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |=> !data_rdy);
endmodule

bind conv_seq conv_seq_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ph_en    (ph_en),
  .filt_clr (filt_clr),
  .filt_stb (filt_stb),
  .busy     (busy),
  .data_rdy (data_rdy)
);

// File: tb/conv_seq_tb_top.sv
module conv_seq_tb_top;
  localparam int N = 8;
  localparam int P = 5;
  localparam int S = 3;
  localparam int L = S + 4 * N + P;
  localparam int M = 4 * N + P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       cont = 1'b0;
  logic [3:0] ph_en;
  logic       clr, stb, busy, rdy;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rdy_n = 0, clr_n = 0, stb_n = 0, p0_n = 0, bad = 0;
  int rdy_last = -1, clr_last = -1;
  logic [3:0] prev_ph = 4'b0000;

  always #5 clk = ~clk;

  conv_seq #(.SAMPLES(N), .POST_DLY(P), .STARTUP_CYC(S)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cont_mode (cont),
    .ph_en     (ph_en),
    .filt_clr  (clr),
    .filt_stb  (stb),
    .busy      (busy),
    .data_rdy  (rdy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy) begin rdy_last = cyc; rdy_n++; end
      if (clr) begin clr_last = cyc; clr_n++; end
      if (stb) begin stb_n++; if (ph_en != 4'b1000) bad++; end
      if (ph_en[0]) p0_n++;
      if (ph_en != 4'b0000 && $countones(ph_en) != 1) bad++;
      if (prev_ph != 4'b0000 && ph_en != 4'b0000 &&
          ph_en != {prev_ph[2:0], prev_ph[3]}) bad++;
      if (!busy && (ph_en != 4'b0000 || stb || clr)) bad++;
      prev_ph = ph_en;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_rdy(input int target);
    for (int i = 0; i < 1000 && rdy_n < target; i++) step(1);
  endtask

  task automatic t_reset();
    step(1);
    chk(!busy && ph_en == 0 && !clr && !stb && !rdy, "R1 reset outputs",
        {busy, ph_en, clr, stb, rdy}, 0);
    step(20);
    chk(stb_n == 0 && !busy && rdy_n == 0, "R2 idle stays quiet", stb_n + rdy_n, 0);
  endtask

  task automatic t_oneshot();
    int c, r0, c0, s0, p0;
    r0 = rdy_n; c0 = clr_n; s0 = stb_n; p0 = p0_n;
    c = cyc;
    cs_n = 1'b0;
    step(1);
    chk(busy && ph_en == 0, "R4 wake begins without phases", {busy, ph_en}, 5'b10000);
    wait_rdy(r0 + 1);
    chk(rdy_last == c + 1 + L, "R7 data ready cycle", rdy_last, c + 1 + L);
    chk(!busy, "R8 busy low at data ready", busy, 0);
    chk(clr_last == c + 1 + S, "R4 first phase after wake", clr_last, c + 1 + S);
    chk(clr_n - c0 == 1, "R6 one clear per conversion", clr_n - c0, 1);
    chk(stb_n - s0 == N, "R5 strobes per conversion", stb_n - s0, N);
    chk(p0_n - p0 == N, "R3 samples per conversion", p0_n - p0, N);
    chk(bad == 0, "R3 phase order and gating", bad, 0);
    cs_n = 1'b1;
    step(10);
    chk(!busy && rdy_n == r0 + 1, "R8 stays in shutdown", rdy_n - r0, 1);
  endtask

  task automatic t_ignore();
    int c, r0;
    r0 = rdy_n;
    c = cyc;
    cs_n = 1'b0;
    step(15);
    cs_n = 1'b1;
    step(2);
    cs_n = 1'b0;
    wait_rdy(r0 + 1);
    chk(rdy_last == c + 1 + L, "R10 timing unchanged by second edge", rdy_last, c + 1 + L);
    step(20);
    chk(rdy_n == r0 + 1 && !busy, "R10 no extra conversion", rdy_n - r0, 1);
  endtask

  task automatic t_rise();
    int s0, r0;
    s0 = stb_n; r0 = rdy_n;
    cs_n = 1'b1;
    step(20);
    chk(!busy && stb_n == s0 && rdy_n == r0, "R2 rising edge does not start",
        stb_n - s0, 0);
  endtask

  task automatic t_cont();
    int c, r0, c0, t1, t2;
    r0 = rdy_n; c0 = clr_n;
    c = cyc;
    cont = 1'b1;
    wait_rdy(r0 + 1);
    t1 = rdy_last;
    chk(t1 == c + 1 + L, "R9 first continuous result", t1, c + 1 + L);
    chk(busy && clr_last == t1, "R9 chained conversion starts at data ready", clr_last, t1);
    wait_rdy(r0 + 2);
    t2 = rdy_last;
    chk(t2 - t1 == M, "R9 data ready period", t2 - t1, M);
    cont = 1'b0;
    wait_rdy(r0 + 3);
    chk(rdy_last - t2 == M, "R9 final conversion completes", rdy_last - t2, M);
    chk(!busy, "R9 shutdown after continuous cleared", busy, 0);
    chk(clr_n - c0 == 3, "R6 clear per chained conversion", clr_n - c0, 3);
    step(30);
    chk(rdy_n == r0 + 3 && !busy, "R9 no result after shutdown", rdy_n - r0, 3);
    chk(bad == 0, "R3 phase order in continuous mode", bad, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_ignore();
    t_rise();
    t_cont();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule